// File: doc/BRIEF.md
# Dual-Pipe Issue and Stall Controller

This block sits at the decode stage of a five-stage integer pipeline that has a floating-point side pipeline attached. On every cycle it decides whether the instruction held in decode may leave. An integer instruction goes to the single execute stage. A floating-point add, multiply or divide goes to its own unit. The units are a four-stage pipelined adder, a seven-stage pipelined multiplier and a divider that is not pipelined. The hazard detectors and the arithmetic units live outside this block. They report to it through flags: a RAW hazard, a WAW hazard, a busy flag for each unit, a flag that the execute stage holds a real instruction, a taken-jump flag, and a count of floating-point results waiting to leave their units.

When the instruction cannot leave, the block names one cause and increments one counter for that cause. RAW wins over WAW, and WAW wins over any structural cause. For RAW, WAW and floating-point unit conflicts it also asks the pipeline to place a bubble in execute. Separately, it steers the single path into the memory stage: a finished floating-point result always wins that path over the integer execute stage, and every cycle in which the path is contested is counted. A taken jump that leaves decode asks for the decode slot to be flushed, so that fetch can restart from the new address.

Top module: `issue_ctrl`

## Requirements
- R1: After reset all six stall counters read zero; each counter is CNT_W bits wide.
- R2: With id_valid high and raw_haz high, no issue enable is asserted, ex_bubble is high, and cnt_raw is one higher after the next clock edge.
- R3: With id_valid high, waw_haz high and raw_haz low, no issue enable is asserted, ex_bubble is high, and cnt_waw is one higher after the next edge.
- R4: id_class encodes 0 = integer, 1 = FP add, 2 = FP multiply, 3 = FP divide. A divide (3) that finds div_busy high does not issue, raises ex_bubble and increments cnt_div.
- R5: An FP add (1) or FP multiply (2) whose own unit busy flag is high does not issue, raises ex_bubble and increments cnt_fu. The busy flags of the other units have no effect on it.
- R6: An integer instruction (0) with ex_busy high does not issue, leaves ex_bubble low and increments cnt_ex. ex_busy has no effect on FP instructions.
- R7: When several decode stall causes are present at once, only the counter of the highest-priority cause increments. The order is RAW, then WAW, then structural.
- R8: With no stall cause present, exactly the issue enable that matches id_class is high, and no decode stall counter changes.
- R9: id_flush is high only when jump_taken is high and an integer instruction issues in that cycle.
- R10: mem_sel_fp is high whenever fp_ready_cnt is nonzero. cnt_mem increments when fp_ready_cnt is nonzero and either ex_busy is high or fp_ready_cnt exceeds one. This count is independent of the decode stall causes.
- R11: A counter at its all-ones value holds that value when its cause recurs.
- R12: With id_valid low, no issue enable, ex_bubble or id_flush is asserted, and no decode stall counter changes, whatever the hazard and busy flags say.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_valid | input | 1 | Decode holds an instruction |
| id_class | input | 2 | Instruction class (0 int, 1 add, 2 mul, 3 div) |
| ex_busy | input | 1 | Execute holds a non-bubble instruction |
| add_busy | input | 1 | FP adder cannot accept |
| mul_busy | input | 1 | FP multiplier cannot accept |
| div_busy | input | 1 | FP divider occupied |
| raw_haz | input | 1 | RAW hazard on the decode instruction |
| waw_haz | input | 1 | WAW hazard on the decode instruction |
| jump_taken | input | 1 | Decode instruction is a taken jump |
| fp_ready_cnt | input | RDY_W | FP results ready to leave their units |
| issue_int | output | 1 | Issue to execute |
| issue_add | output | 1 | Issue to FP adder |
| issue_mul | output | 1 | Issue to FP multiplier |
| issue_div | output | 1 | Issue to FP divider |
| ex_bubble | output | 1 | Insert a bubble in execute |
| id_flush | output | 1 | Replace decode with a bubble and refetch |
| mem_sel_fp | output | 1 | FP result takes the path into MEM |
| cnt_raw | output | CNT_W | RAW stall count |
| cnt_waw | output | CNT_W | WAW stall count |
| cnt_div | output | CNT_W | Divider-busy stall count |
| cnt_fu | output | CNT_W | Adder/multiplier-busy stall count |
| cnt_ex | output | CNT_W | Execute-busy stall count |
| cnt_mem | output | CNT_W | MEM-path conflict count |

## Verification
A wrong priority or a wrong cause decode shows up in the same cycle on the issue enables and on ex_bubble. One edge later it also shows as the wrong counter moving, and a cross-check between two counters exposes it. A stuck or wrapping counter shows only when its cause recurs, so the saturation case drives one cause well past the maximum of a narrow counter. The MEM steering is combinational, so any error in it appears in the same cycle as the inputs that cause it.

// File: rtl/issue_pkg.sv
package issue_pkg;

  typedef enum logic [1:0] {
    OP_INT  = 2'd0,
    OP_FADD = 2'd1,
    OP_FMUL = 2'd2,
    OP_FDIV = 2'd3
  } op_class_e;

  typedef enum logic [2:0] {
    SC_NONE = 3'd0,
    SC_RAW  = 3'd1,
    SC_WAW  = 3'd2,
    SC_DIV  = 3'd3,
    SC_FU   = 3'd4,
    SC_EX   = 3'd5
  } stall_cause_e;

  localparam int N_CNT  = 6;
  localparam int IX_RAW = 0;
  localparam int IX_WAW = 1;
  localparam int IX_DIV = 2;
  localparam int IX_FU  = 3;
  localparam int IX_EX  = 4;
  localparam int IX_MEM = 5;

  // Decode-side stall cause; priority: data hazards first, then structure.
  function automatic stall_cause_e pick_cause(
    input logic      valid,
    input op_class_e cls,
    input logic      raw,
    input logic      waw,
    input logic      exb,
    input logic      addb,
    input logic      mulb,
    input logic      divb
  );
    stall_cause_e c;
    c = SC_NONE;
    if (valid) begin
      if (raw)                          c = SC_RAW;
      else if (waw)                     c = SC_WAW;
      else begin
        unique case (cls)
          OP_INT:  c = exb  ? SC_EX  : SC_NONE;
          OP_FADD: c = addb ? SC_FU  : SC_NONE;
          OP_FMUL: c = mulb ? SC_FU  : SC_NONE;
          OP_FDIV: c = divb ? SC_DIV : SC_NONE;
          default: c = SC_NONE;
        endcase
      end
    end
    return c;
  endfunction

  // A bubble goes into execute for every decode stall except execute-busy.
  function automatic logic wants_bubble(input stall_cause_e c);
    return (c == SC_RAW) || (c == SC_WAW) || (c == SC_DIV) || (c == SC_FU);
  endfunction

endpackage

// File: rtl/issue_arbiter.sv
module issue_arbiter
  import issue_pkg::*;
(
  input  logic         id_valid,
  input  op_class_e    cls,
  input  logic         ex_busy,
  input  logic         add_busy,
  input  logic         mul_busy,
  input  logic         div_busy,
  input  logic         raw_haz,
  input  logic         waw_haz,
  input  logic         jump_taken,
  output stall_cause_e cause,
  output logic         issue_int,
  output logic         issue_add,
  output logic         issue_mul,
  output logic         issue_div,
  output logic         ex_bubble,
  output logic         id_flush
);

  logic go;

  always_comb begin
    cause     = pick_cause(id_valid, cls, raw_haz, waw_haz,
                           ex_busy, add_busy, mul_busy, div_busy);
    go        = id_valid && (cause == SC_NONE);
    issue_int = go && (cls == OP_INT);
    issue_add = go && (cls == OP_FADD);
    issue_mul = go && (cls == OP_FMUL);
    issue_div = go && (cls == OP_FDIV);
    ex_bubble = wants_bubble(cause);
    id_flush  = issue_int && jump_taken;
  end

endmodule

// File: rtl/fp_mem_merge.sv
module fp_mem_merge #(
  parameter int RDY_W = 2
) (
  input  logic [RDY_W-1:0] fp_ready_cnt,
  input  logic             ex_busy,
  output logic             mem_sel_fp,
  output logic             mem_conflict
);

  localparam logic [RDY_W-1:0] ONE = RDY_W'(1);

  always_comb begin
    mem_sel_fp   = (fp_ready_cnt != '0);
    mem_conflict = mem_sel_fp && (ex_busy || (fp_ready_cnt > ONE));
  end

endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n)               q <= '0;
    else if (inc && q != '1)  q <= q + W'(1);
  end

endmodule

// File: rtl/issue_ctrl.sv
module issue_ctrl
  import issue_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int RDY_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             id_valid,
  input  logic [1:0]       id_class,
  input  logic             ex_busy,
  input  logic             add_busy,
  input  logic             mul_busy,
  input  logic             div_busy,
  input  logic             raw_haz,
  input  logic             waw_haz,
  input  logic             jump_taken,
  input  logic [RDY_W-1:0] fp_ready_cnt,
  output logic             issue_int,
  output logic             issue_add,
  output logic             issue_mul,
  output logic             issue_div,
  output logic             ex_bubble,
  output logic             id_flush,
  output logic             mem_sel_fp,
  output logic [CNT_W-1:0] cnt_raw,
  output logic [CNT_W-1:0] cnt_waw,
  output logic [CNT_W-1:0] cnt_div,
  output logic [CNT_W-1:0] cnt_fu,
  output logic [CNT_W-1:0] cnt_ex,
  output logic [CNT_W-1:0] cnt_mem
);

  stall_cause_e     cause;
  logic             mem_conflict;
  logic [N_CNT-1:0] stall_inc;
  logic [CNT_W-1:0] cnt_q [N_CNT];

  issue_arbiter u_arb (
    .id_valid   (id_valid),
    .cls        (op_class_e'(id_class)),
    .ex_busy    (ex_busy),
    .add_busy   (add_busy),
    .mul_busy   (mul_busy),
    .div_busy   (div_busy),
    .raw_haz    (raw_haz),
    .waw_haz    (waw_haz),
    .jump_taken (jump_taken),
    .cause      (cause),
    .issue_int  (issue_int),
    .issue_add  (issue_add),
    .issue_mul  (issue_mul),
    .issue_div  (issue_div),
    .ex_bubble  (ex_bubble),
    .id_flush   (id_flush)
  );

  fp_mem_merge #(.RDY_W(RDY_W)) u_merge (
    .fp_ready_cnt (fp_ready_cnt),
    .ex_busy      (ex_busy),
    .mem_sel_fp   (mem_sel_fp),
    .mem_conflict (mem_conflict)
  );

  always_comb begin
    stall_inc         = '0;
    stall_inc[IX_RAW] = (cause == SC_RAW);
    stall_inc[IX_WAW] = (cause == SC_WAW);
    stall_inc[IX_DIV] = (cause == SC_DIV);
    stall_inc[IX_FU]  = (cause == SC_FU);
    stall_inc[IX_EX]  = (cause == SC_EX);
    stall_inc[IX_MEM] = mem_conflict;
  end

  for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
    sat_counter #(.W(CNT_W)) u_c (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (stall_inc[g]),
      .q     (cnt_q[g])
    );
  end

  assign cnt_raw = cnt_q[IX_RAW];
  assign cnt_waw = cnt_q[IX_WAW];
  assign cnt_div = cnt_q[IX_DIV];
  assign cnt_fu  = cnt_q[IX_FU];
  assign cnt_ex  = cnt_q[IX_EX];
  assign cnt_mem = cnt_q[IX_MEM];

endmodule

// File: rtl/issue_ctrl_chk.sv
module issue_ctrl_chk #(
  parameter int CNT_W = 32,
  parameter int RDY_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             id_valid,
  input logic [1:0]       id_class,
  input logic             ex_busy,
  input logic             add_busy,
  input logic             mul_busy,
  input logic             div_busy,
  input logic             raw_haz,
  input logic             waw_haz,
  input logic             jump_taken,
  input logic [RDY_W-1:0] fp_ready_cnt,
  input logic             issue_int,
  input logic             issue_add,
  input logic             issue_mul,
  input logic             issue_div,
  input logic             ex_bubble,
  input logic             id_flush,
  input logic             mem_sel_fp,
  input logic [CNT_W-1:0] cnt_raw,
  input logic [CNT_W-1:0] cnt_waw,
  input logic [CNT_W-1:0] cnt_div,
  input logic [CNT_W-1:0] cnt_fu,
  input logic [CNT_W-1:0] cnt_ex,
  input logic [CNT_W-1:0] cnt_mem
);

  assert_one_issue_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({issue_int, issue_add, issue_mul, issue_div}));

  assert_raw_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && raw_haz && cnt_raw != '1) |=> cnt_raw == CNT_W'($past(cnt_raw) + CNT_W'(1)));

  assert_raw_blocks_waw_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && raw_haz) |=> $stable(cnt_waw) && $stable(cnt_fu) && $stable(cnt_ex));

  assert_saturate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_raw == '1) |=> (cnt_raw == '1));

  assert_flush_needs_int_R9: assert property (@(posedge clk) disable iff (!rst_n)
    id_flush |-> (issue_int && jump_taken));

  assert_no_bubble_on_issue_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ex_bubble |-> !(issue_int || issue_add || issue_mul || issue_div));

  assert_mem_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fp_ready_cnt != '0 && (ex_busy || fp_ready_cnt > RDY_W'(1)) && cnt_mem != '1)
      |=> cnt_mem == CNT_W'($past(cnt_mem) + CNT_W'(1)));

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !id_valid |=> $stable(cnt_raw) && $stable(cnt_waw) && $stable(cnt_div)
                  && $stable(cnt_fu) && $stable(cnt_ex));

endmodule

bind issue_ctrl issue_ctrl_chk #(.CNT_W(CNT_W), .RDY_W(RDY_W)) u_chk (.*);

// File: tb/sim_issue_ctrl.sv
module sim_issue_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int W  = 4;
  localparam int RW = 2;
  localparam logic [W-1:0] MAXV = '1;

  typedef struct {
    logic [3:0] iss;       // {div, mul, add, int}
    logic       bub;
    logic       flush;
    logic       msel;
    logic [W-1:0] cnt [6]; // raw, waw, div, fu, ex, mem
    string      req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic id_valid = 1'b0;
  logic [1:0] id_class = 2'd0;
  logic ex_busy = 1'b0, add_busy = 1'b0, mul_busy = 1'b0, div_busy = 1'b0;
  logic raw_haz = 1'b0, waw_haz = 1'b0, jump_taken = 1'b0;
  logic [RW-1:0] fp_ready_cnt = '0;
  logic issue_int, issue_add, issue_mul, issue_div, ex_bubble, id_flush, mem_sel_fp;
  logic [W-1:0] cnt_raw, cnt_waw, cnt_div, cnt_fu, cnt_ex, cnt_mem;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  exp_t q[$];
  logic [W-1:0] model [6];

  always #(CLK_PERIOD/2) clk = ~clk;

  issue_ctrl #(.CNT_W(W), .RDY_W(RW)) u0 (
    .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_class(id_class),
    .ex_busy(ex_busy), .add_busy(add_busy), .mul_busy(mul_busy), .div_busy(div_busy),
    .raw_haz(raw_haz), .waw_haz(waw_haz), .jump_taken(jump_taken),
    .fp_ready_cnt(fp_ready_cnt),
    .issue_int(issue_int), .issue_add(issue_add), .issue_mul(issue_mul),
    .issue_div(issue_div), .ex_bubble(ex_bubble), .id_flush(id_flush),
    .mem_sel_fp(mem_sel_fp),
    .cnt_raw(cnt_raw), .cnt_waw(cnt_waw), .cnt_div(cnt_div),
    .cnt_fu(cnt_fu), .cnt_ex(cnt_ex), .cnt_mem(cnt_mem)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] bump(input logic [W-1:0] v);
    return (v == MAXV) ? v : v + W'(1);
  endfunction

  // Driver: applies one cycle of stimulus and queues what must follow.
  task automatic drive(input string req, input bit v, input int cls,
                       input bit exb, input bit ab, input bit mb, input bit db,
                       input bit raw, input bit waw, input bit jmp, input int rdy);
    exp_t e;
    bit unit_full, hazard, blocked;
    int which;
    @(negedge clk);
    id_valid = v; id_class = 2'(cls); ex_busy = exb; add_busy = ab;
    mul_busy = mb; div_busy = db; raw_haz = raw; waw_haz = waw;
    jump_taken = jmp; fp_ready_cnt = RW'(rdy);
    unit_full = (cls == 0) ? exb : (cls == 1) ? ab : (cls == 2) ? mb : db;
    hazard = raw || waw;
    blocked = v && (hazard || unit_full);
    which = -1;
    if (v) begin
      if (raw)            which = 0;
      else if (waw)       which = 1;
      else if (unit_full) which = (cls == 3) ? 2 : (cls == 0) ? 4 : 3;
    end
    e.iss = '0;
    if (v && !blocked) e.iss[cls] = 1'b1;
    e.bub   = (which >= 0 && which <= 3);
    e.flush = v && !blocked && cls == 0 && jmp;
    e.msel  = (rdy > 0);
    if (which >= 0) model[which] = bump(model[which]);
    if (rdy > 0 && (exb || rdy > 1)) model[5] = bump(model[5]);
    for (int i = 0; i < 6; i++) e.cnt[i] = model[i];
    e.req = req;
    q.push_back(e);
  endtask

  // Monitor: compares each queued item one step after the edge it waits for.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(e.req, "issue",  {issue_div, issue_mul, issue_add, issue_int}, e.iss);
        check(e.req, "bubble", ex_bubble, e.bub);
        check(e.req, "flush",  id_flush, e.flush);
        check(e.req, "memsel", mem_sel_fp, e.msel);
        check(e.req, "cnt_raw", cnt_raw, e.cnt[0]);
        check(e.req, "cnt_waw", cnt_waw, e.cnt[1]);
        check(e.req, "cnt_div", cnt_div, e.cnt[2]);
        check(e.req, "cnt_fu",  cnt_fu,  e.cnt[3]);
        check(e.req, "cnt_ex",  cnt_ex,  e.cnt[4]);
        check(e.req, "cnt_mem", cnt_mem, e.cnt[5]);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 6; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    check("R1", "cnt_raw", cnt_raw, 0); check("R1", "cnt_waw", cnt_waw, 0);
    check("R1", "cnt_div", cnt_div, 0); check("R1", "cnt_fu",  cnt_fu,  0);
    check("R1", "cnt_ex",  cnt_ex,  0); check("R1", "cnt_mem", cnt_mem, 0);

    //      req   v cls exb ab mb db raw waw jmp rdy
    drive("R12", 0, 0, 1, 1, 1, 1, 1, 1, 1, 0);
    drive("R8",  1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    drive("R8",  1, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    drive("R8",  1, 2, 0, 0, 0, 0, 0, 0, 0, 0);
    drive("R8",  1, 3, 0, 0, 0, 0, 0, 0, 0, 0);
    drive("R9",  1, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    drive("R9",  1, 1, 0, 0, 0, 0, 0, 0, 1, 0);
    drive("R9",  1, 0, 0, 0, 0, 0, 1, 0, 1, 0);
    drive("R2",  1, 2, 0, 0, 0, 0, 1, 0, 0, 0);
    drive("R3",  1, 1, 0, 0, 0, 0, 0, 1, 0, 0);
    drive("R7",  1, 3, 0, 0, 0, 1, 1, 1, 0, 0);
    drive("R7",  1, 3, 0, 0, 0, 1, 0, 1, 0, 0);
    drive("R7",  1, 0, 1, 0, 0, 0, 0, 1, 0, 0);
    drive("R4",  1, 3, 0, 0, 0, 1, 0, 0, 0, 0);
    drive("R4",  1, 3, 0, 1, 1, 0, 0, 0, 0, 0);
    drive("R5",  1, 1, 0, 1, 0, 0, 0, 0, 0, 0);
    drive("R5",  1, 2, 0, 0, 1, 0, 0, 0, 0, 0);
    drive("R5",  1, 2, 0, 1, 0, 1, 0, 0, 0, 0);
    drive("R5",  1, 1, 0, 0, 1, 1, 0, 0, 0, 0);
    drive("R6",  1, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    drive("R6",  1, 1, 1, 0, 0, 0, 0, 0, 0, 0);
    drive("R10", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    drive("R10", 0, 0, 1, 0, 0, 0, 0, 0, 0, 1);
    drive("R10", 0, 0, 0, 0, 0, 0, 0, 0, 0, 2);
    drive("R10", 0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    drive("R10", 1, 0, 1, 0, 0, 0, 1, 0, 0, 3);
    for (int k = 0; k < 20; k++) drive("R11", 1, 0, 1, 0, 0, 0, 1, 0, 0, 2);
    drive("R12", 0, 3, 0, 0, 0, 1, 0, 0, 0, 0);
    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule